// File: doc/BRIEF.md
# Control-Byte Register Access Target

This block sits behind the bus layer of a two-wire serial target and gives the controller access to a file of sixteen 16-bit registers. Bus timing is already resolved upstream: the block sees strobes for START (including repeated START), STOP and "this target was addressed", plus one strobe per received byte and one per byte the controller clocks out. After the target is addressed, the first byte is a control byte. Its top bit tells a register access apart from a converter command. For a register access, the byte also gives a 4-bit register address and the direction. Two data bytes then move, high byte first, and every received byte gets an ACK or NACK one cycle later.

Access rights are set per address by a parameter map. By default, addresses 0x0–0x3, 0xD and 0xF are writable and held inside the block. The other ten addresses are read-only and come from measurement inputs. A write aimed at a read-only address, or a control byte with a reserved bit set, puts the block into a refusal state. In that state it rejects every byte until a STOP arrives and the target is addressed again. A command-class control byte is acknowledged and passed on as a one-cycle strobe. It never touches the register file.

Top module: `cbr_target`

## Requirements
- R1: After reset, the block is unaddressed, every writable register reads 0, and ack_valid_o, tx_valid_o and cmd_stb_o are low.
- R2: Control byte layout: bit 7 = 0 means register access and bit 7 = 1 means command. Bits 5..2 carry the register address. Bit 0 is the direction (1 = read, 0 = write). Bits 6 and 1 are reserved and must be 0. Every received byte is answered by ack_valid_o high one cycle after rx_valid_i, with ack_o = 1 for ACK and 0 for NACK.
- R3: A write control byte to a writable address (0x0–0x3, 0xD, 0xF) is ACKed and is followed by two ACKed data bytes, high byte first. The register changes only when the second byte is accepted, and the block then waits for a new control byte.
- R4: A write control byte to a read-only address (0x4–0xC, 0xE) is NACKed and changes no register. On cfg_o, writable addresses 0x0..0x3 sit in slots 0..3, 0xD in slot 4 and 0xF in slot 5. On meas_i, addresses 0x4..0xC come from slots 0..8 and 0xE from slot 9.
- R5: After a refusal, every byte is NACKed, including bytes after a repeated START and a new address match. Only a STOP followed by an address match restores normal access.
- R6: A register-access control byte with bit 6 or bit 1 set is NACKed and starts the same refusal state as in R5.
- R7: A control byte with bit 7 = 1 is ACKed. cmd_stb_o then pulses for exactly one cycle, together with the ACK, with cmd_o equal to bits 6..0. No register changes.
- R8: After an ACKed read control byte, the first two tx_req_i pulses return the high byte and then the low byte on tx_data_o, with tx_valid_o high the cycle after each request. A writable register returns its stored value.
- R9: A read of a read-only address returns the meas_i value present in the cycle the control byte was accepted, even if meas_i changes before the data bytes are fetched.
- R10: A write cut off by a STOP or a repeated START after only its high byte leaves the register unchanged.
- R11: Bytes received before an address match, or after a STOP, are NACKed and have no effect.
- R12: A tx_req_i outside a read data phase returns 0xFF. A byte received during a read data phase is NACKed and does not disturb the pending read data.
- R13: Writable registers may be written one after another, in any address order, within one addressed transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start_i | input | 1 | START or repeated START seen on the bus |
| bus_stop_i | input | 1 | STOP seen on the bus |
| addr_hit_i | input | 1 | Address frame matched this target |
| rx_valid_i | input | 1 | A byte from the controller is available |
| rx_data_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | Response for the previous received byte is valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| tx_req_i | input | 1 | Controller clocks out one byte |
| tx_valid_o | output | 1 | tx_data_o holds the requested byte |
| tx_data_o | output | 8 | Byte returned to the controller |
| cmd_stb_o | output | 1 | One-cycle strobe for a command control byte |
| cmd_o | output | 7 | Payload bits of the command byte |
| meas_i | input | NUM_RO×16 | Read-only register sources, one slot per read-only address |
| cfg_o | output | NUM_WR×16 | Contents of the writable registers |

## Verification
On every cycle, the assertions check these properties: each accepted byte gets a response in the next cycle, the refusal state persists until a STOP and always answers NACK, a command strobe traces back to a received byte with the top bit set and carries an ACK, writable contents change only right after a received byte, and a STOP leaves the block unaddressed. Some behaviour needs whole sequences, so only the bench scenarios can show it. That covers the high-byte-first ordering, commit only on the second byte, loss of a half-finished write, clearing of refusal only by STOP plus a new address, and the snapshot of measurement inputs taken when the read control byte is accepted.

// File: rtl/cbr_pkg.sv
`timescale 1ns/1ps
package cbr_pkg;

    localparam int BYTE_W   = 8;
    localparam int REG_W    = 16;
    localparam int ADDR_W   = 4;
    localparam int NUM_REGS = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CTRL,
        S_WR_HI,
        S_WR_LO,
        S_RD_HI,
        S_RD_LO,
        S_REFUSE
    } st_e;

    typedef struct packed {
        logic              is_cmd;
        logic              rsvd_bad;
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic [6:0]        payload;
    } ctl_t;

    function automatic ctl_t decode_ctl(input logic [BYTE_W-1:0] b);
        ctl_t c;
        c.is_cmd   = b[7];
        c.rsvd_bad = b[6] | b[1];
        c.addr     = b[5:2];
        c.rd       = b[0];
        c.payload  = b[6:0];
        return c;
    endfunction

    function automatic int count_class(input logic [NUM_REGS-1:0] map, input logic cls);
        int n;
        n = 0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (map[i] == cls) n++;
        end
        return n;
    endfunction

    // Position of an address among the addresses sharing its access class.
    function automatic int class_index(input logic [NUM_REGS-1:0] map,
                                       input logic [ADDR_W-1:0] a);
        int n;
        n = 0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (i < int'(a) && map[i] == map[a]) n++;
        end
        return n;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cbr_decode.sv
`timescale 1ns/1ps
module cbr_decode
    import cbr_pkg::*;
#(
    parameter logic [NUM_REGS-1:0] RW_MAP = 16'hA00F
)(
    input  logic [BYTE_W-1:0] byte_i,
    output ctl_t              ctl_o,
    output logic              writable_o
);

    always_comb begin
        ctl_o      = decode_ctl(byte_i);
        writable_o = RW_MAP[ctl_o.addr];
    end

endmodule

// File: rtl/cbr_regbank.sv
`timescale 1ns/1ps
module cbr_regbank
    import cbr_pkg::*;
#(
    parameter logic [NUM_REGS-1:0] RW_MAP = 16'hA00F,
    localparam int NUM_WR = count_class(RW_MAP, 1'b1),
    localparam int NUM_RO = NUM_REGS - NUM_WR
)(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we_i,
    input  logic [ADDR_W-1:0]            waddr_i,
    input  logic [REG_W-1:0]             wdata_i,
    input  logic [ADDR_W-1:0]            raddr_i,
    input  logic [NUM_RO-1:0][REG_W-1:0] meas_i,
    output logic [REG_W-1:0]             rdata_o,
    output logic [NUM_WR-1:0][REG_W-1:0] cfg_o
);

    localparam int WI_W = idx_width(NUM_WR);
    localparam int RI_W = idx_width(NUM_RO);

    logic [NUM_WR-1:0][REG_W-1:0] store_q;
    logic [WI_W-1:0]              wslot;
    logic [WI_W-1:0]              rslot_w;
    logic [RI_W-1:0]              rslot_r;

    always_comb begin
        wslot   = WI_W'(class_index(RW_MAP, waddr_i));
        rslot_w = WI_W'(class_index(RW_MAP, raddr_i));
        rslot_r = RI_W'(class_index(RW_MAP, raddr_i));
    end

    for (genvar g = 0; g < NUM_WR; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                store_q[g] <= '0;
            end else if (we_i && RW_MAP[waddr_i] && wslot == WI_W'(g)) begin
                store_q[g] <= wdata_i;
            end
        end
    end

    always_comb begin
        if (RW_MAP[raddr_i]) rdata_o = store_q[rslot_w];
        else                 rdata_o = meas_i[rslot_r];
    end

    assign cfg_o = store_q;

endmodule

// File: rtl/cbr_target.sv
`timescale 1ns/1ps
module cbr_target
    import cbr_pkg::*;
#(
    parameter logic [NUM_REGS-1:0] RW_MAP = 16'hA00F,
    localparam int NUM_WR = count_class(RW_MAP, 1'b1),
    localparam int NUM_RO = NUM_REGS - NUM_WR
)(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_start_i,
    input  logic                         bus_stop_i,
    input  logic                         addr_hit_i,
    input  logic                         rx_valid_i,
    input  logic [BYTE_W-1:0]            rx_data_i,
    output logic                         ack_valid_o,
    output logic                         ack_o,
    input  logic                         tx_req_i,
    output logic                         tx_valid_o,
    output logic [BYTE_W-1:0]            tx_data_o,
    output logic                         cmd_stb_o,
    output logic [6:0]                   cmd_o,
    input  logic [NUM_RO-1:0][REG_W-1:0] meas_i,
    output logic [NUM_WR-1:0][REG_W-1:0] cfg_o
);

    st_e               st_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [BYTE_W-1:0] hi_q;
    logic [REG_W-1:0]  snap_q;

    ctl_t              ctl;
    logic              ctl_wr_ok;
    logic [REG_W-1:0]  rdata;
    logic              bus_evt;
    logic              commit;

    cbr_decode #(.RW_MAP(RW_MAP)) u_dec (
        .byte_i     (rx_data_i),
        .ctl_o      (ctl),
        .writable_o (ctl_wr_ok)
    );

    assign bus_evt = bus_stop_i | bus_start_i | addr_hit_i;
    assign commit  = rx_valid_i && !bus_evt && st_q == S_WR_LO;

    cbr_regbank #(.RW_MAP(RW_MAP)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we_i    (commit),
        .waddr_i (tgt_q),
        .wdata_i ({hi_q, rx_data_i}),
        .raddr_i (ctl.addr),
        .meas_i  (meas_i),
        .rdata_o (rdata),
        .cfg_o   (cfg_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= S_IDLE;
            tgt_q       <= '0;
            hi_q        <= '0;
            snap_q      <= '0;
            ack_valid_o <= 1'b0;
            ack_o       <= 1'b0;
            tx_valid_o  <= 1'b0;
            tx_data_o   <= '0;
            cmd_stb_o   <= 1'b0;
            cmd_o       <= '0;
        end else begin
            ack_valid_o <= 1'b0;
            tx_valid_o  <= 1'b0;
            cmd_stb_o   <= 1'b0;
            if (bus_stop_i) begin
                st_q <= S_IDLE;
            end else if (bus_start_i) begin
                if (st_q != S_REFUSE) st_q <= S_IDLE;
            end else if (addr_hit_i) begin
                if (st_q != S_REFUSE) st_q <= S_CTRL;
            end else if (rx_valid_i) begin
                ack_valid_o <= 1'b1;
                ack_o       <= 1'b0;
                unique case (st_q)
                    S_CTRL: begin
                        if (ctl.is_cmd) begin
                            ack_o     <= 1'b1;
                            cmd_stb_o <= 1'b1;
                            cmd_o     <= ctl.payload;
                        end else if (ctl.rsvd_bad) begin
                            st_q <= S_REFUSE;
                        end else if (ctl.rd) begin
                            ack_o  <= 1'b1;
                            snap_q <= rdata;
                            st_q   <= S_RD_HI;
                        end else if (ctl_wr_ok) begin
                            ack_o <= 1'b1;
                            tgt_q <= ctl.addr;
                            st_q  <= S_WR_HI;
                        end else begin
                            st_q <= S_REFUSE;
                        end
                    end
                    S_WR_HI: begin
                        ack_o <= 1'b1;
                        hi_q  <= rx_data_i;
                        st_q  <= S_WR_LO;
                    end
                    S_WR_LO: begin
                        ack_o <= 1'b1;
                        st_q  <= S_CTRL;
                    end
                    default: begin
                        ack_o <= 1'b0;
                    end
                endcase
            end else if (tx_req_i) begin
                tx_valid_o <= 1'b1;
                unique case (st_q)
                    S_RD_HI: begin
                        tx_data_o <= snap_q[REG_W-1:BYTE_W];
                        st_q      <= S_RD_LO;
                    end
                    S_RD_LO: begin
                        tx_data_o <= snap_q[BYTE_W-1:0];
                        st_q      <= S_CTRL;
                    end
                    default: begin
                        tx_data_o <= '1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/cbr_checker.sv
`timescale 1ns/1ps
module cbr_checker
    import cbr_pkg::*;
#(
    parameter int NUM_WR = 6
)(
    input logic                         clk,
    input logic                         rst,
    input logic                         bus_start_i,
    input logic                         bus_stop_i,
    input logic                         addr_hit_i,
    input logic                         rx_valid_i,
    input logic [BYTE_W-1:0]            rx_data_i,
    input logic                         ack_valid_o,
    input logic                         ack_o,
    input logic                         tx_req_i,
    input logic                         tx_valid_o,
    input logic                         cmd_stb_o,
    input logic [NUM_WR-1:0][REG_W-1:0] cfg_o,
    input st_e                          st
);

    a_r2_byte_answered: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_i && !bus_start_i && !bus_stop_i && !addr_hit_i) |=> ack_valid_o);

    a_r5_refusal_sticky: assert property (@(posedge clk) disable iff (rst)
        (st == S_REFUSE && !bus_stop_i) |=> (st == S_REFUSE));

    a_r5_refusal_nack: assert property (@(posedge clk) disable iff (rst)
        (st == S_REFUSE && rx_valid_i && !bus_stop_i) |=> (ack_valid_o && !ack_o));

    a_r7_cmd_origin: assert property (@(posedge clk) disable iff (rst)
        cmd_stb_o |-> ($past(rx_valid_i) && $past(rx_data_i[7])));

    a_r7_cmd_acked: assert property (@(posedge clk) disable iff (rst)
        cmd_stb_o |-> (ack_valid_o && ack_o));

    a_r4_cfg_needs_byte: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_o) |-> $past(rx_valid_i));

    a_r8_tx_needs_req: assert property (@(posedge clk) disable iff (rst)
        tx_valid_o |-> $past(tx_req_i));

    a_r11_stop_unaddresses: assert property (@(posedge clk) disable iff (rst)
        bus_stop_i |=> (st == S_IDLE));

endmodule

bind cbr_target cbr_checker #(.NUM_WR(NUM_WR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_start_i (bus_start_i),
    .bus_stop_i  (bus_stop_i),
    .addr_hit_i  (addr_hit_i),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .ack_valid_o (ack_valid_o),
    .ack_o       (ack_o),
    .tx_req_i    (tx_req_i),
    .tx_valid_o  (tx_valid_o),
    .cmd_stb_o   (cmd_stb_o),
    .cfg_o       (cfg_o),
    .st          (st_q)
);

// File: tb/sim_cbr_target.sv
`timescale 1ns/1ps
module sim_cbr_target;

    localparam int NUM_WR = 6;
    localparam int NUM_RO = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_start = 1'b0, bus_stop = 1'b0, addr_hit = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic tx_req = 1'b0;
    logic ack_valid_o, ack_o, tx_valid_o, cmd_stb_o;
    logic [7:0] tx_data_o;
    logic [6:0] cmd_o;
    logic [NUM_RO-1:0][15:0] meas;
    logic [NUM_WR-1:0][15:0] cfg_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] model [16];

    bit    ackq [$];
    string ackt [$];
    logic [7:0] txq [$];
    string      txt [$];

    always #4 clk = ~clk;

    cbr_target u0 (
        .clk(clk), .rst(rst),
        .bus_start_i(bus_start), .bus_stop_i(bus_stop), .addr_hit_i(addr_hit),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .ack_valid_o(ack_valid_o), .ack_o(ack_o),
        .tx_req_i(tx_req), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
        .cmd_stb_o(cmd_stb_o), .cmd_o(cmd_o),
        .meas_i(meas), .cfg_o(cfg_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected responses as the design produces them.
    always @(negedge clk) begin
        if (ack_valid_o) begin
            if (ackq.size() == 0) begin
                check(1'b0, "R2 unexpected response", 32'(ack_o), 32'hx);
            end else begin
                bit e;
                string t;
                e = ackq.pop_front();
                t = ackt.pop_front();
                check(ack_o == e, t, 32'(ack_o), 32'(e));
            end
        end
        if (tx_valid_o) begin
            if (txq.size() == 0) begin
                check(1'b0, "R8 unexpected tx byte", 32'(tx_data_o), 32'hx);
            end else begin
                logic [7:0] e;
                string t;
                e = txq.pop_front();
                t = txt.pop_front();
                check(tx_data_o == e, t, 32'(tx_data_o), 32'(e));
            end
        end
    end

    function automatic int slot_of(input int a);
        if (a < 4) return a;
        if (a == 13) return 4;
        return 5;
    endfunction

    function automatic logic [7:0] ctl(input int a, input bit rd);
        return {2'b00, 4'(a), 1'b0, rd};
    endfunction

    task automatic pulse_start;
        @(negedge clk); bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
    endtask
    task automatic pulse_stop;
        @(negedge clk); bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
    endtask
    task automatic pulse_addr;
        @(negedge clk); addr_hit = 1'b1; @(negedge clk); addr_hit = 1'b0;
    endtask
    task automatic open_tr;
        pulse_start;
        pulse_addr;
    endtask

    task automatic send(input logic [7:0] b, input bit exp, input string tag);
        ackq.push_back(exp);
        ackt.push_back(tag);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic fetch(input logic [7:0] exp, input string tag);
        txq.push_back(exp);
        txt.push_back(tag);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
    endtask

    task automatic wr_reg(input int a, input logic [15:0] v, input string tag);
        send(ctl(a, 1'b0), 1'b1, tag);
        send(v[15:8], 1'b1, tag);
        send(v[7:0], 1'b1, tag);
        model[a] = v;
    endtask

    task automatic check_cfg(input string tag);
        int wa [6] = '{0, 1, 2, 3, 13, 15};
        for (int i = 0; i < 6; i++) begin
            check(cfg_o[slot_of(wa[i])] == model[wa[i]], tag,
                  32'(cfg_o[slot_of(wa[i])]), 32'(model[wa[i]]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        for (int i = 0; i < NUM_RO; i++) meas[i] = 16'hA000 + 16'(i * 16'h0111);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(ack_valid_o == 1'b0, "R1 ack_valid", 32'(ack_valid_o), 0);
        check(tx_valid_o == 1'b0, "R1 tx_valid", 32'(tx_valid_o), 0);
        check(cmd_stb_o == 1'b0, "R1 cmd_stb", 32'(cmd_stb_o), 0);
        check_cfg("R1 cfg zero");

        // R11: bytes before any address match are refused and inert
        send(ctl(0, 1'b0), 1'b0, "R11 unaddressed ctl");
        send(8'h77, 1'b0, "R11 unaddressed data");
        check_cfg("R11 no effect");

        // R3, R13: writes in mixed order in one transaction
        open_tr;
        send(ctl(0, 1'b0), 1'b1, "R3 ctl");
        send(8'h12, 1'b1, "R3 hi");
        check_cfg("R3 no commit after hi");
        send(8'h34, 1'b1, "R3 lo");
        model[0] = 16'h1234;
        check_cfg("R3 commit");
        wr_reg(15, 16'hBEEF, "R13 addr15");
        wr_reg(13, 16'h0A0B, "R13 addr13");
        wr_reg(2, 16'hC3C3, "R13 addr2");
        check_cfg("R13 cfg");
        pulse_stop;

        // R8: readback of writable registers, high byte first
        open_tr;
        send(ctl(0, 1'b1), 1'b1, "R8 rd ctl");
        fetch(8'h12, "R8 hi");
        fetch(8'h34, "R8 lo");
        send(ctl(15, 1'b1), 1'b1, "R8 rd ctl 15");
        fetch(8'hBE, "R8 hi 15");
        fetch(8'hEF, "R8 lo 15");
        fetch(8'hFF, "R12 idle tx");
        pulse_stop;

        // R9: snapshot taken at control byte acceptance
        open_tr;
        send(ctl(4, 1'b1), 1'b1, "R9 rd ctl 4");
        meas[0] = 16'hFFFF;
        fetch(8'hA0, "R9 hi slot0");
        fetch(8'h00, "R9 lo slot0");
        send(ctl(14, 1'b1), 1'b1, "R9 rd ctl 14");
        fetch(8'hA9, "R9 hi slot9");
        fetch(8'h99, "R9 lo slot9");
        send(ctl(12, 1'b1), 1'b1, "R9 rd ctl 12");
        fetch(8'hA8, "R9 hi slot8");
        fetch(8'h88, "R9 lo slot8");
        pulse_stop;

        // R12: byte during read data phase NACKed, read data intact
        open_tr;
        send(ctl(13, 1'b1), 1'b1, "R12 rd ctl");
        send(8'h55, 1'b0, "R12 rx in read");
        fetch(8'h0A, "R12 hi kept");
        fetch(8'h0B, "R12 lo kept");
        pulse_stop;

        // R4, R5: illegal write and sticky refusal
        open_tr;
        send(ctl(5, 1'b0), 1'b0, "R4 write ro");
        check_cfg("R4 no change");
        send(8'h12, 1'b0, "R5 data after refusal");
        pulse_start;
        pulse_addr;
        send(ctl(1, 1'b0), 1'b0, "R5 after restart");
        send(8'h99, 1'b0, "R5 still refused");
        check_cfg("R5 no change");
        pulse_stop;
        open_tr;
        wr_reg(1, 16'h5566, "R5 cleared");
        check_cfg("R5 cleared cfg");
        pulse_stop;

        // R6: reserved bits
        open_tr;
        send({2'b01, 4'd2, 1'b0, 1'b0}, 1'b0, "R6 bit6");
        send(ctl(2, 1'b0), 1'b0, "R6 sticky");
        pulse_stop;
        open_tr;
        send({2'b00, 4'd2, 1'b1, 1'b0}, 1'b0, "R6 bit1");
        send(ctl(2, 1'b1), 1'b0, "R6 sticky rd");
        pulse_stop;
        check_cfg("R6 no change");

        // R7: command byte
        open_tr;
        send(8'h85, 1'b1, "R7 cmd");
        check(cmd_stb_o == 1'b1, "R7 strobe", 32'(cmd_stb_o), 1);
        check(cmd_o == 7'h05, "R7 payload", 32'(cmd_o), 32'h05);
        @(negedge clk);
        check(cmd_stb_o == 1'b0, "R7 one cycle", 32'(cmd_stb_o), 0);
        check_cfg("R7 no change");
        wr_reg(3, 16'h7E7E, "R7 write after cmd");
        check_cfg("R7 cfg");
        pulse_stop;

        // R10: partial writes cut by STOP and by repeated START
        open_tr;
        send(ctl(3, 1'b0), 1'b1, "R10 ctl");
        send(8'hDE, 1'b1, "R10 hi");
        pulse_stop;
        check_cfg("R10 stop");
        open_tr;
        send(ctl(3, 1'b0), 1'b1, "R10 ctl2");
        send(8'hAD, 1'b1, "R10 hi2");
        pulse_start;
        check_cfg("R10 restart");
        pulse_stop;

        // R11: after STOP, writes need a new address match
        send(ctl(0, 1'b0), 1'b0, "R11 after stop");
        send(8'h00, 1'b0, "R11 data after stop");
        check_cfg("R11 after stop cfg");

        repeat (3) @(negedge clk);
        check(ackq.size() == 0, "R2 responses outstanding", 32'(ackq.size()), 0);
        check(txq.size() == 0, "R8 tx outstanding", 32'(txq.size()), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule